// File: doc/BRIEF.md
# Data-Enable Gated Blanking Inserter

This block sits on a three-channel pixel path in front of the digital-to-analog converters. It either passes each pixel through or replaces it with the blanking code for that channel. One input pin has two uses. A control bit decides whether that pin carries a field ID or a data-enable. The data-enable use applies only when the timing generator runs in computer-graphics (VESA) mode. While data-enable is high, the input pixel reaches the output. While it is low, every channel carries its blanking code.

A colour-space bit places the blanking codes:

- **RGB mode:** all three channels blank at code 0.
- **YPbPr mode:** the luma channel blanks at code 0, and the two colour-difference channels blank at mid-scale.

The gating decision, the data and the field ID are registered together in one stage. The outputs therefore stay mutually aligned, one clock after the inputs. Channel 0 carries Y or G, channel 1 carries Pb or B, and channel 2 carries Pr or R. Analog scaling, level offsets and sync-tip insertion belong to later stages.

Top module: `de_blank_inserter`

## Requirements
- R1: While rst_ni is low, pix_o is all zero and fid_o is 0. The clear takes effect asynchronously.
- R2: Every output is registered with exactly one clock of latency. A change on any input, control bits included, shows on the outputs at the first rising edge after the change.
- R3: With pin_is_de_i = 0, the shared pin acts as a field ID. fid_o equals the pin as sampled one clock earlier, and pixels pass through whatever the pin level.
- R4: With pin_is_de_i = 1, vesa_mode_i = 1 and the shared pin at 1, pix_o equals pix_i from one clock earlier.
- R5: With pin_is_de_i = 1, vesa_mode_i = 1 and the shared pin at 0, the input pixel is discarded and each channel is replaced by its blanking code.
- R6: With rgb_mode_i = 1, the blanking code is 0 on all three channels.
- R7: With rgb_mode_i = 0, the blanking code is 0 on channel 0 and 512 (2^(CH_W-1)) on channels 1 and 2.
- R8: With vesa_mode_i = 0, data-enable is taken as always high, so pixels pass through unchanged for any level of the shared pin.
- R9: With pin_is_de_i = 1, the pin carries no field ID, and fid_o is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 3x10 | Input pixel; [0]=Y/G, [1]=Pb/B, [2]=Pr/R |
| fid_de_i | input | 1 | Shared pin: field ID or data-enable |
| vesa_mode_i | input | 1 | Timing generator is in computer-graphics mode |
| pin_is_de_i | input | 1 | 1: the shared pin is read as data-enable |
| rgb_mode_i | input | 1 | 1: RGB blanking levels, 0: YPbPr blanking levels |
| pix_o | output | 3x10 | Gated pixel, one clock after the input |
| fid_o | output | 1 | Registered field ID |

## Verification
A wrong pin decode shows as a blanked pixel in a cycle where data should pass, or as a field ID that follows the pin when it should be 0. Either error is visible one clock after the stimulus.

A wrong blank-level choice shows up only on blanked cycles. A colour-difference channel at 0 instead of 512 in YPbPr mode exposes it, again in the next cycle.

A stale or extra pipeline stage misaligns data against the enable. When the enable toggles every cycle, this gives a mismatch on every cycle.

// File: rtl/de_blank_pkg.sv
package de_blank_pkg;
  localparam int unsigned NUM_CH = 3;

  typedef enum logic [1:0] {
    PIN_FIELD_ID = 2'd0,
    PIN_DATA_EN  = 2'd1,
    PIN_IGNORED  = 2'd2
  } pin_use_e;
endpackage

// File: rtl/de_blank_pin_decode.sv
module de_blank_pin_decode
  import de_blank_pkg::*;
(
  input  logic     pin_i,
  input  logic     vesa_mode_i,
  input  logic     pin_is_de_i,
  output pin_use_e pin_use_o,
  output logic     de_o,
  output logic     fid_o
);
  always_comb begin
    if (!pin_is_de_i)     pin_use_o = PIN_FIELD_ID;
    else if (vesa_mode_i) pin_use_o = PIN_DATA_EN;
    else                  pin_use_o = PIN_IGNORED;
  end

  always_comb begin
    de_o  = 1'b1;
    fid_o = 1'b0;
    unique case (pin_use_o)
      PIN_FIELD_ID: fid_o = pin_i;
      PIN_DATA_EN:  de_o  = pin_i;
      default:      ;
    endcase
  end
endmodule

// File: rtl/de_blank_level_sel.sv
module de_blank_level_sel
  import de_blank_pkg::*;
#(
  parameter int unsigned CH_W = 10
) (
  input  logic                             rgb_mode_i,
  output logic [NUM_CH-1:0][CH_W-1:0]      blank_o
);
  localparam logic [CH_W-1:0] BOTTOM = '0;
  localparam logic [CH_W-1:0] MID    = CH_W'(1) << (CH_W - 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c == 0) begin : g_luma
      assign blank_o[c] = BOTTOM;
    end else begin : g_chroma
      // colour-difference channels sit at mid-scale outside RGB mode
      assign blank_o[c] = rgb_mode_i ? BOTTOM : MID;
    end
  end
endmodule

// File: rtl/de_blank_gate_ch.sv
module de_blank_gate_ch #(
  parameter int unsigned CH_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            de_i,
  input  logic [CH_W-1:0] pix_i,
  input  logic [CH_W-1:0] blank_i,
  output logic [CH_W-1:0] pix_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_o <= '0;
    else         pix_o <= de_i ? pix_i : blank_i;
  end
endmodule

// File: rtl/de_blank_inserter.sv
module de_blank_inserter
  import de_blank_pkg::*;
#(
  parameter int unsigned CH_W = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CH-1:0][CH_W-1:0] pix_i,
  input  logic                        fid_de_i,
  input  logic                        vesa_mode_i,
  input  logic                        pin_is_de_i,
  input  logic                        rgb_mode_i,
  output logic [NUM_CH-1:0][CH_W-1:0] pix_o,
  output logic                        fid_o
);
  localparam logic [CH_W-1:0] MID = CH_W'(1) << (CH_W - 1);

  pin_use_e                    pin_use;
  logic                        de;
  logic                        fid_d;
  logic [NUM_CH-1:0][CH_W-1:0] blank;

  de_blank_pin_decode u_decode (
    .pin_i       (fid_de_i),
    .vesa_mode_i (vesa_mode_i),
    .pin_is_de_i (pin_is_de_i),
    .pin_use_o   (pin_use),
    .de_o        (de),
    .fid_o       (fid_d)
  );

  de_blank_level_sel #(.CH_W(CH_W)) u_levels (
    .rgb_mode_i (rgb_mode_i),
    .blank_o    (blank)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
    de_blank_gate_ch #(.CH_W(CH_W)) u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .de_i    (de),
      .pix_i   (pix_i[c]),
      .blank_i (blank[c]),
      .pix_o   (pix_o[c])
    );
  end

  // field ID shares the pixel register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fid_o <= 1'b0;
    else         fid_o <= fid_d;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pix_o == '0 && fid_o == 1'b0));

  // R3
  fid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_is_de_i |=> (fid_o == $past(fid_de_i) && pix_o == $past(pix_i)));

  // R4
  pass_when_de_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_is_de_i && vesa_mode_i && fid_de_i) |=> pix_o == $past(pix_i));

  // R6
  rgb_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_is_de_i && vesa_mode_i && !fid_de_i && rgb_mode_i) |=> pix_o == '0);

  // R7
  ypbpr_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_is_de_i && vesa_mode_i && !fid_de_i && !rgb_mode_i) |=>
      (pix_o[0] == '0 && pix_o[1] == MID && pix_o[2] == MID));

  // R8
  non_vesa_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vesa_mode_i |=> pix_o == $past(pix_i));

  // R9
  fid_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_is_de_i |=> fid_o == 1'b0);

  // R5
  decode_de_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_use == PIN_DATA_EN) |-> (de == fid_de_i && fid_d == 1'b0));
endmodule

// File: tb/de_blank_inserter_tb_top.sv
module de_blank_inserter_tb_top;
  localparam int unsigned W = 10;
  localparam int unsigned NV = 10;

  typedef struct packed {
    logic         pin_de;
    logic         vesa;
    logic         pin;
    logic         rgb;
    logic [W-1:0] c0, c1, c2;
    logic [W-1:0] e0, e1, e2;
    logic         efid;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R3: field-ID use, pin low
    '{1'b0,1'b0,1'b0,1'b1, 10'd341,10'd682,10'd1023, 10'd341,10'd682,10'd1023, 1'b0, 4'd3},
    // R3: field-ID use, pin high, data still passes
    '{1'b0,1'b1,1'b1,1'b0, 10'd5,10'd6,10'd7, 10'd5,10'd6,10'd7, 1'b1, 4'd3},
    // R4: data-enable high
    '{1'b1,1'b1,1'b1,1'b1, 10'd100,10'd200,10'd300, 10'd100,10'd200,10'd300, 1'b0, 4'd4},
    // R5, R6: blanked, RGB levels
    '{1'b1,1'b1,1'b0,1'b1, 10'd100,10'd200,10'd300, 10'd0,10'd0,10'd0, 1'b0, 4'd6},
    // R5, R7: blanked, YPbPr levels
    '{1'b1,1'b1,1'b0,1'b0, 10'd100,10'd200,10'd300, 10'd0,10'd512,10'd512, 1'b0, 4'd7},
    // R8: not VESA, pin low ignored
    '{1'b1,1'b0,1'b0,1'b0, 10'd11,10'd22,10'd33, 10'd11,10'd22,10'd33, 1'b0, 4'd8},
    // R9: pin high, no field ID out
    '{1'b1,1'b0,1'b1,1'b1, 10'd1023,10'd0,10'd512, 10'd1023,10'd0,10'd512, 1'b0, 4'd9},
    // R3: field-ID use in VESA mode, pin low does not blank
    '{1'b0,1'b1,1'b0,1'b0, 10'd9,10'd8,10'd7, 10'd9,10'd8,10'd7, 1'b0, 4'd3},
    // R7: full-scale input replaced
    '{1'b1,1'b1,1'b0,1'b0, 10'd1023,10'd1023,10'd1023, 10'd0,10'd512,10'd512, 1'b0, 4'd7},
    // R4: YPbPr mode, enable high
    '{1'b1,1'b1,1'b1,1'b0, 10'd1,10'd2,10'd3, 10'd1,10'd2,10'd3, 1'b0, 4'd4}
  };

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [2:0][W-1:0]   pix_i = '0;
  logic                fid_de_i = 1'b0;
  logic                vesa_mode_i = 1'b0;
  logic                pin_is_de_i = 1'b0;
  logic                rgb_mode_i = 1'b1;
  logic [2:0][W-1:0]   pix_o;
  logic                fid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  de_blank_inserter #(.CH_W(W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pix_i       (pix_i),
    .fid_de_i    (fid_de_i),
    .vesa_mode_i (vesa_mode_i),
    .pin_is_de_i (pin_is_de_i),
    .rgb_mode_i  (rgb_mode_i),
    .pix_o       (pix_o),
    .fid_o       (fid_o)
  );

  task automatic check(input int req, input logic [2:0][W-1:0] exp_pix, input logic exp_fid);
    checks++;
    if (pix_o !== exp_pix || fid_o !== exp_fid) begin
      errors++;
      $display("FAIL R%0d: pix=%h/%h/%h fid=%b expected pix=%h/%h/%h fid=%b", req,
               pix_o[2], pix_o[1], pix_o[0], fid_o,
               exp_pix[2], exp_pix[1], exp_pix[0], exp_fid);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared while reset is held, inputs active
    pix_i = {10'd3, 10'd2, 10'd1};
    fid_de_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(1, '0, 1'b0);
    rst_ni = 1'b1;

    // table walk: drive at one falling edge, sample at the next
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      pin_is_de_i = VECS[i].pin_de;
      vesa_mode_i = VECS[i].vesa;
      fid_de_i    = VECS[i].pin;
      rgb_mode_i  = VECS[i].rgb;
      pix_i       = {VECS[i].c2, VECS[i].c1, VECS[i].c0};
      @(negedge clk_i);
      check(int'(VECS[i].req), {VECS[i].e2, VECS[i].e1, VECS[i].e0}, VECS[i].efid);
    end

    // R2: enable toggled every cycle, each output tracks the previous cycle
    pin_is_de_i = 1'b1; vesa_mode_i = 1'b1; rgb_mode_i = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic [2:0][W-1:0] exp_p;
      @(negedge clk_i);
      fid_de_i = k[0];
      pix_i = {W'(k * 37 + 3), W'(k * 37 + 2), W'(k * 37 + 1)};
      exp_p = k[0] ? pix_i : {10'd512, 10'd512, 10'd0};
      @(negedge clk_i);
      check(2, exp_p, 1'b0);
    end

    // R2: colour-space switch during blanking shows on the next edge
    @(negedge clk_i);
    fid_de_i = 1'b0; rgb_mode_i = 1'b0;
    @(negedge clk_i);
    check(7, {10'd512, 10'd512, 10'd0}, 1'b0);
    rgb_mode_i = 1'b1;
    check(2, {10'd512, 10'd512, 10'd0}, 1'b0);
    @(negedge clk_i);
    check(6, '0, 1'b0);

    // R3: field ID tracks the pin with one clock delay
    pin_is_de_i = 1'b0;
    fid_de_i = 1'b1;
    pix_i = {10'd77, 10'd66, 10'd55};
    @(negedge clk_i);
    check(3, {10'd77, 10'd66, 10'd55}, 1'b1);

    // R1: asynchronous clear mid-run
    #1 rst_ni = 1'b0;
    #0.5;
    check(1, '0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule